// File: doc/BRIEF.md
# Shared-Prescaler Interval Timer and Watchdog

This block holds an 8-bit free-running event counter and a watchdog, and the two share a single 8-bit binary prescaler. A mode register chooses four things. The first is where counter events come from: a one-cycle instruction-clock tick from the core, or edges on an external input pin. The second is which pin edge counts. The third is the prescale ratio. The fourth is whether the prescaler divides counter events or watchdog timeouts. The counter value can be written and read at any time, and it wraps from its highest value back to zero.

The watchdog has its own base divider, driven by a slow tick from a free-running oscillator. When the base divider completes a period, the block takes a timeout: either directly, or after the prescaler when the prescaler is assigned to the watchdog. On a timeout it raises a one-cycle reset request. The core keeps the watchdog from expiring by pulsing the clear strobe. Entering sleep also restarts the watchdog count. Two configuration inputs decide whether the watchdog is always on or may be turned on by software through the mode register.

Top module: `tsp_timer_top`

## Requirements
- R1: After reset the mode register reads 8'hFF, the counter reads 8'h00 and no reset request is raised.
- R2: A counter write loads `cnt_wdata` at the next clock edge and takes priority over a simultaneous count event. While the prescaler is assigned to the counter, the write also clears the prescaler.
- R3: With mode bit 3 at 0, the prescaler divides counter events. A prescale field value n (mode bits 2:0) gives one increment per 2^(n+1) source events, so ratios run from 1:2 to 1:256.
- R4: With mode bit 3 at 1, the counter advances once per source event. The watchdog timeout is divided by 2^n for field value n, from 1:1 to 1:128.
- R5: Mode bit 5 selects the count source: 0 uses `cyc_tick`, 1 uses edges on `ext_pin`. Events from the unselected source have no effect on the counter.
- R6: Mode bit 4 selects the counted pin edge: 0 counts low-to-high, 1 counts high-to-low. The pin passes through two synchroniser flops, so with no division a pin change before clock edge k shows in `cnt_rdata` after edge k+2.
- R7: The counter wraps from 8'hFF to 8'h00 on an increment.
- R8: An enabled watchdog completes a base period every `WDT_BASE` cycles in which `wdt_tick` is high. The reset request `wdt_rst` is a pulse one cycle long.
- R9: The watchdog is enabled when `cfg_wdt_force` is 1, or when `cfg_wdt_sw_ok` is 1 and mode bit 7 is 0. While it is disabled its count is held at zero and no reset request is raised.
- R10: `wdt_clr` and `sleep_req` each restart the watchdog base count, and they also clear the prescaler when it is assigned to the watchdog.
- R11: A mode write that changes bit 3 clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_rdata | output | 8 | Current mode register value |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| cnt_rdata | output | 8 | Current counter value |
| cyc_tick | input | 1 | Instruction-cycle event, one cycle per event |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Watchdog oscillator tick, one cycle per tick |
| wdt_clr | input | 1 | Clear-watchdog strobe |
| sleep_req | input | 1 | Sleep entry strobe, also restarts the watchdog |
| cfg_wdt_force | input | 1 | Configuration: watchdog always on |
| cfg_wdt_sw_ok | input | 1 | Configuration: software may enable the watchdog |
| wdt_rst | output | 1 | Watchdog reset request pulse |

## Verification
The assertions check several properties on every cycle. The counter never moves by more than one step unless it is written. A detected pin edge is never repeated on the next cycle. The watchdog count is zero after a clear or while the watchdog is disabled. A reset request appears only when the watchdog was enabled, and it never lasts two cycles. The exact division ratios under both prescaler assignments, the synchroniser latency, the edge and source selection, wrap-around and the prescaler clears on a counter write or a reassignment can only be shown by the bench's directed event sequences.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
    localparam int MODE_W   = 8;
    localparam int PS_W     = 3;
    localparam int BIT_PSA  = 3;
    localparam int BIT_EDGE = 4;
    localparam int BIT_SRC  = 5;
    localparam int BIT_WOFF = 7;

    typedef struct packed {
        logic            wd_off;
        logic            ext_src;
        logic            fall_edge;
        logic            to_wdt;
        logic [PS_W-1:0] ps;
    } mode_t;

    function automatic mode_t decode_mode(input logic [MODE_W-1:0] m);
        mode_t r;
        r.wd_off    = m[BIT_WOFF];
        r.ext_src   = m[BIT_SRC];
        r.fall_edge = m[BIT_EDGE];
        r.to_wdt    = m[BIT_PSA];
        r.ps        = m[PS_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/tsp_edge.sv
module tsp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_i,
    output logic ev_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } edge_st_t;

    edge_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.s1   = pin_i;
        s_d.s2   = s_q.s1;
        s_d.prev = s_q.s2;
        ev_o     = fall_i ? (~s_q.s2 & s_q.prev) : (s_q.s2 & ~s_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6
    edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o |=> (!ev_o || (fall_i != $past(fall_i))));
endmodule

// File: rtl/tsp_prescale.sv
module tsp_prescale #(
    parameter int PRE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ev_i,
    input  logic                       clr_i,
    input  logic [$clog2(PRE_W+1)-1:0] log_ratio_i,
    output logic                       fire_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t          s_d, s_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(log_ratio_i));
        end
    end

    always_comb begin
        s_d    = s_q;
        fire_o = ev_i & ~clr_i & ((s_q.cnt & mask) == mask);
        if (clr_i)     s_d.cnt = '0;
        else if (ev_i) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R11
    pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.cnt == '0));
endmodule

// File: rtl/tsp_counter.sv
module tsp_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] q_o
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i)       s_d.val = wdata_i;
        else if (inc_i) s_d.val = s_q.val + 1'b1;
        q_o = s_q.val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ((q_o == $past(q_o)) || (q_o == CNT_W'($past(q_o) + 1'b1))));
endmodule

// File: rtl/tsp_watchdog.sv
module tsp_watchdog #(
    parameter int WDT_BASE = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic clr_i,
    output logic ovf_o
);
    localparam int BW = (WDT_BASE > 2) ? $clog2(WDT_BASE) : 1;
    localparam logic [BW-1:0] LAST = BW'(WDT_BASE - 1);

    typedef struct packed {
        logic [BW-1:0] cnt;
    } wd_st_t;

    wd_st_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        ovf_o = 1'b0;
        if (!en_i || clr_i) begin
            s_d.cnt = '0;
        end else if (tick_i) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt = '0;
                ovf_o   = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R10
    wd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.cnt == '0));

    // R9
    wd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (s_q.cnt == '0));
endmodule

// File: rtl/tsp_timer_top.sv
module tsp_timer_top
    import tsp_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int PRE_W    = 8,
    parameter int WDT_BASE = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic [MODE_W-1:0] mode_rdata,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  cnt_rdata,
    input  logic              cyc_tick,
    input  logic              ext_pin,
    input  logic              wdt_tick,
    input  logic              wdt_clr,
    input  logic              sleep_req,
    input  logic              cfg_wdt_force,
    input  logic              cfg_wdt_sw_ok,
    output logic              wdt_rst
);
    localparam int LR_W = $clog2(PRE_W + 1);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              rst_req;
    } top_st_t;

    top_st_t         s_d, s_q;
    mode_t           m;
    logic            pin_ev, src_ev, wd_en, wd_clr, base_ovf;
    logic            pre_in, pre_clr, pre_fire, cnt_inc, timeout;
    logic [LR_W-1:0] log_ratio;

    always_comb begin
        m         = decode_mode(s_q.mode);
        src_ev    = m.ext_src ? pin_ev : cyc_tick;
        wd_en     = cfg_wdt_force | (cfg_wdt_sw_ok & ~m.wd_off);
        wd_clr    = wdt_clr | sleep_req;
        pre_in    = m.to_wdt ? base_ovf : src_ev;
        pre_clr   = (cnt_wr & ~m.to_wdt)
                  | (mode_wr & (mode_wdata[BIT_PSA] != s_q.mode[BIT_PSA]))
                  | (m.to_wdt & wd_clr);
        log_ratio = m.to_wdt ? LR_W'(m.ps) : LR_W'(m.ps) + 1'b1;
        cnt_inc   = m.to_wdt ? src_ev : pre_fire;
        timeout   = m.to_wdt ? pre_fire : base_ovf;

        s_d         = s_q;
        s_d.rst_req = timeout & wd_en;
        if (mode_wr) s_d.mode = mode_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode    <= '1;
            s_q.rst_req <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_rdata = s_q.mode;
    assign wdt_rst    = s_q.rst_req;

    tsp_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .fall_i (m.fall_edge),
        .ev_o   (pin_ev)
    );

    tsp_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (pre_in),
        .clr_i       (pre_clr),
        .log_ratio_i (log_ratio),
        .fire_o      (pre_fire)
    );

    tsp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cnt_wr),
        .wdata_i (cnt_wdata),
        .inc_i   (cnt_inc),
        .q_o     (cnt_rdata)
    );

    tsp_watchdog #(.WDT_BASE(WDT_BASE)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (wd_en),
        .tick_i (wdt_tick),
        .clr_i  (wd_clr),
        .ovf_o  (base_ovf)
    );

    // R9
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> $past(wd_en));

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);
endmodule

// File: tb/sim_tsp_timer_top.sv
module sim_tsp_timer_top;
    localparam int WB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_rdata;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_rdata;
    logic       cyc_tick = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       sleep_req = 1'b0;
    logic       cfg_wdt_force = 1'b0;
    logic       cfg_wdt_sw_ok = 1'b0;
    logic       wdt_rst;

    int total = 0;
    int bad = 0;
    int rst_seen = 0;

    always #4 clk = ~clk;

    tsp_timer_top #(.WDT_BASE(WB)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_rdata(mode_rdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cnt_rdata(cnt_rdata), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
        .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .sleep_req(sleep_req),
        .cfg_wdt_force(cfg_wdt_force), .cfg_wdt_sw_ok(cfg_wdt_sw_ok),
        .wdt_rst(wdt_rst)
    );

    always @(negedge clk) if (wdt_rst) rst_seen <= rst_seen + 1;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_mode(input logic [7:0] v);
        mode_wr = 1'b1; mode_wdata = v; @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic set_cnt(input logic [7:0] v);
        cnt_wr = 1'b1; cnt_wdata = v; @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_tick = 1'b1; @(negedge clk);
        end
        cyc_tick = 1'b0;
    endtask

    task automatic wticks(input int n);
        for (int i = 0; i < n; i++) begin
            wdt_tick = 1'b1; @(negedge clk);
        end
        wdt_tick = 1'b0;
        cyc(2);
    endtask

    task automatic t_reset;
        check("R1 mode", mode_rdata, 8'hFF);
        check("R1 cnt", cnt_rdata, 0);
        check("R1 rst", wdt_rst, 0);
    endtask

    task automatic t_write;
        set_mode(8'b1100_1000);
        set_cnt(8'hA5);
        check("R2 load", cnt_rdata, 8'hA5);
        cnt_wr = 1'b1; cnt_wdata = 8'h3C; cyc_tick = 1'b1; @(negedge clk);
        cnt_wr = 1'b0; cyc_tick = 1'b0;
        check("R2 priority", cnt_rdata, 8'h3C);
        set_mode(8'b1100_0000);
        set_cnt(8'h00);
        ticks(1);
        set_cnt(8'h0A);
        ticks(1);
        check("R2 prescaler cleared", cnt_rdata, 8'h0A);
        ticks(1);
        check("R2 after clear", cnt_rdata, 8'h0B);
    endtask

    task automatic t_ratio;
        set_mode(8'b1100_0000);
        set_cnt(0);
        ticks(4);
        check("R3 ratio 2", cnt_rdata, 2);
        set_mode(8'b1100_0010);
        set_cnt(0);
        ticks(7);
        check("R3 ratio 8 short", cnt_rdata, 0);
        ticks(1);
        check("R3 ratio 8", cnt_rdata, 1);
        ticks(16);
        check("R3 ratio 8 more", cnt_rdata, 3);
        set_mode(8'b1100_0111);
        set_cnt(0);
        ticks(255);
        check("R3 ratio 256 short", cnt_rdata, 0);
        ticks(1);
        check("R3 ratio 256", cnt_rdata, 1);
    endtask

    task automatic t_psa_change;
        set_mode(8'b1100_0000);
        set_cnt(0);
        ticks(1);
        set_mode(8'b1100_1000);
        set_mode(8'b1100_0000);
        ticks(1);
        check("R11 cleared", cnt_rdata, 0);
        ticks(1);
        check("R11 resumes", cnt_rdata, 1);
    endtask

    task automatic t_undivided_wrap;
        set_mode(8'b1100_1011);
        set_cnt(8'h10);
        ticks(3);
        check("R4 undivided", cnt_rdata, 8'h13);
        set_cnt(8'hFF);
        ticks(1);
        check("R7 wrap", cnt_rdata, 8'h00);
    endtask

    task automatic t_pin;
        set_mode(8'b1110_1000);
        set_cnt(0);
        ticks(5);
        check("R5 ticks ignored", cnt_rdata, 0);
        ext_pin = 1'b1;
        cyc(2);
        check("R6 latency", cnt_rdata, 0);
        cyc(1);
        check("R6 rising", cnt_rdata, 1);
        ext_pin = 1'b0; cyc(4);
        check("R6 fall ignored", cnt_rdata, 1);
        set_mode(8'b1111_1000);
        ext_pin = 1'b1; cyc(4);
        check("R6 rise ignored", cnt_rdata, 1);
        ext_pin = 1'b0; cyc(4);
        check("R6 falling", cnt_rdata, 2);
        set_mode(8'b1100_1000);
        ext_pin = 1'b1; cyc(4);
        ext_pin = 1'b0; cyc(4);
        check("R5 pin ignored", cnt_rdata, 2);
    endtask

    task automatic t_wdt_base;
        int b;
        cfg_wdt_force = 1'b1;
        set_mode(8'b1100_0000);
        b = rst_seen;
        wticks(WB - 1);
        check("R8 early", rst_seen - b, 0);
        wticks(1);
        check("R8 timeout", rst_seen - b, 1);
        wticks(WB);
        check("R8 second", rst_seen - b, 2);
    endtask

    task automatic t_wdt_pre;
        int b;
        set_mode(8'b1100_1001);
        b = rst_seen;
        wticks(2 * WB - 1);
        check("R4 wdt 1:2 early", rst_seen - b, 0);
        wticks(1);
        check("R4 wdt 1:2", rst_seen - b, 1);
    endtask

    task automatic t_wdt_clear;
        int b;
        set_mode(8'b1100_0000);
        b = rst_seen;
        wticks(10);
        wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
        wticks(10);
        check("R10 clr restart", rst_seen - b, 0);
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        wticks(WB - 1);
        check("R10 sleep restart", rst_seen - b, 0);
        wticks(1);
        check("R10 after restart", rst_seen - b, 1);
    endtask

    task automatic t_wdt_enable;
        int b;
        cfg_wdt_force = 1'b0;
        cfg_wdt_sw_ok = 1'b0;
        set_mode(8'b0100_0000);
        b = rst_seen;
        wticks(2 * WB + 3);
        check("R9 sw not allowed", rst_seen - b, 0);
        cfg_wdt_sw_ok = 1'b1;
        wticks(WB - 1);
        check("R9 held at zero", rst_seen - b, 0);
        wticks(1);
        check("R9 sw enabled", rst_seen - b, 1);
        set_mode(8'b1100_0000);
        wticks(2 * WB + 3);
        check("R9 sw disabled", rst_seen - b, 1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_write();
        t_ratio();
        t_psa_change();
        t_undivided_wrap();
        t_pin();
        t_wdt_base();
        t_wdt_pre();
        t_wdt_clear();
        t_wdt_enable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule